// File: doc/BRIEF.md
# Sync Presence Detector

This block decides whether a horizontal and a vertical sync input are live. Each input gets its own checker. The checker counts rising edges inside a fixed gating window and watches for a long stretch with no edge at all. A fast enough pulse train raises the channel's presence flag. A silence as long as one period at the low limit drops the flag again. Any rate between the two limits leaves the flag as it was. This gap between the set limit and the clear limit gives the flag hysteresis, so a sync rate that drifts near one limit does not make the flag chatter.

Both checkers count in ticks of a shared time base, and a prescaler divides the system clock down to make those ticks. One select input chooses between two divide ratios. With the defaults, a tick lasts 1 µs with either an 8 MHz clock (ratio 8) or a 12 MHz clock (ratio 12), so the same rate limits hold for both clocks.

With the defaults, the horizontal flag sets above 10 kHz (10 edges in a 1 ms window). The vertical flag sets above 40 Hz (4 edges in a 100 ms window). Both flags clear after 100 ms without an edge, which is a 10 Hz period. Each flag has a change interrupt. The interrupt latches whenever its flag changes state and stays set until a one-cycle clear pulse arrives.

Top module: `sync_presence_detector`

## Requirements
- R1: After reset, both presence flags and both change interrupts read 0.
- R2: The horizontal flag becomes 1 when H_SET_EDGES rising edges of hsync_in land inside one H_WINDOW-tick gating window. Windows are consecutive and aligned to the tick count.
- R3: The horizontal flag becomes 0 once H_TIMEOUT ticks pass with no rising edge on hsync_in. It still reads 1 at H_TIMEOUT-2 ticks after the last edge.
- R4: A rate too slow to reach the set count but fast enough to avoid the timeout leaves a flag at its previous value, whether that value is 0 or 1.
- R5: The vertical flag sets from its own limits, V_SET_EDGES edges within V_WINDOW ticks, which differ from the horizontal ones.
- R6: The vertical flag becomes 0 once V_TIMEOUT ticks pass with no rising edge on vsync_in.
- R7: One tick lasts DIV_SLOW clock cycles when base_sel is 0 and DIV_FAST cycles when base_sel is 1. A fixed pulse period in clock cycles can therefore set a flag under one setting and not under the other.
- R8: A change interrupt becomes 1 in the same cycle that its flag changes, for both rising and falling flag changes. It stays 1 until it is cleared.
- R9: A one-cycle pulse on a clear input drops that interrupt to 0. If the flag changes in the same cycle as the clear, the interrupt ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hsync_in | input | 1 | Horizontal sync, asynchronous, rising edges counted |
| vsync_in | input | 1 | Vertical sync, asynchronous, rising edges counted |
| base_sel | input | 1 | Time-base select: 0 = DIV_SLOW, 1 = DIV_FAST |
| h_irq_clr | input | 1 | One-cycle clear of the horizontal change interrupt |
| v_irq_clr | input | 1 | One-cycle clear of the vertical change interrupt |
| h_present | output | 1 | Horizontal presence flag |
| v_present | output | 1 | Vertical presence flag |
| h_chg_irq | output | 1 | Horizontal presence change interrupt |
| v_chg_irq | output | 1 | Vertical presence change interrupt |

## Verification
A flag change and a clear pulse for the same interrupt can fall in the same clock edge. The bench first runs a fixed horizontal pulse train from reset and records the exact cycle in which the flag sets. It then replays the same train from reset with the clear pulse placed on that edge, and expects the interrupt to read 1. A third replay places the clear one edge later and expects the interrupt to read 0. Because the prescaler restarts at reset, every replay is cycle-identical, so the collision can be placed exactly.

// File: rtl/sync_presence_pkg.sv
package sync_presence_pkg;
  localparam int unsigned NUM_CH = 2;
  localparam int unsigned CH_H   = 0;
  localparam int unsigned CH_V   = 1;

  // width of a counter that must hold the value n
  function automatic int unsigned hold_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/sync_tick_prescaler.sv
module sync_tick_prescaler #(
  parameter int unsigned DIV_SLOW = 8,
  parameter int unsigned DIV_FAST = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic base_sel,
  output logic tick
);
  import sync_presence_pkg::*;
  localparam int unsigned DIV_MAX = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
  localparam int unsigned CNT_W   = hold_w(DIV_MAX);
  localparam logic [CNT_W-1:0] RELOAD_SLOW = CNT_W'(DIV_SLOW - 1);
  localparam logic [CNT_W-1:0] RELOAD_FAST = CNT_W'(DIV_FAST - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= base_sel ? RELOAD_FAST : RELOAD_SLOW;
    else           cnt_q <= cnt_q - 1'b1;
  end

  // R7
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/sync_presence_channel.sv
module sync_presence_channel #(
  parameter int unsigned WINDOW    = 1000,
  parameter int unsigned SET_EDGES = 10,
  parameter int unsigned TIMEOUT   = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic sync_in,
  input  logic irq_clr,
  output logic present,
  output logic chg_irq
);
  import sync_presence_pkg::*;
  localparam int unsigned WIN_W = hold_w(WINDOW);
  localparam int unsigned EDG_W = hold_w(SET_EDGES);
  localparam int unsigned IDL_W = hold_w(TIMEOUT);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WINDOW - 1);
  localparam logic [EDG_W-1:0] EDG_PRE  = EDG_W'(SET_EDGES - 1);
  localparam logic [EDG_W-1:0] EDG_MAX  = EDG_W'(SET_EDGES);
  localparam logic [IDL_W-1:0] IDL_PRE  = IDL_W'(TIMEOUT - 1);
  localparam logic [IDL_W-1:0] IDL_MAX  = IDL_W'(TIMEOUT);
  localparam bit SINGLE_EDGE = (SET_EDGES == 1);

  logic [2:0]       sync_sh;
  logic             sync_rise;
  logic [WIN_W-1:0] win_cnt;
  logic [EDG_W-1:0] edge_cnt;
  logic [IDL_W-1:0] idle_cnt;
  logic             win_roll, set_hit, idle_hit, present_nxt;

  assign sync_rise = sync_sh[1] & ~sync_sh[2];
  assign win_roll  = tick && (win_cnt == WIN_LAST);
  // an edge in the rollover cycle opens the new window
  assign set_hit   = sync_rise && (win_roll ? SINGLE_EDGE : (edge_cnt == EDG_PRE));
  assign idle_hit  = !sync_rise && tick && (idle_cnt == IDL_PRE);

  always_comb begin
    present_nxt = present;
    if (set_hit)       present_nxt = 1'b1;
    else if (idle_hit) present_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_sh  <= '0;
      win_cnt  <= '0;
      edge_cnt <= '0;
      idle_cnt <= '0;
      present  <= 1'b0;
      chg_irq  <= 1'b0;
    end else begin
      sync_sh <= {sync_sh[1:0], sync_in};
      if (win_roll)  win_cnt <= '0;
      else if (tick) win_cnt <= win_cnt + 1'b1;
      if (win_roll)
        edge_cnt <= EDG_W'(sync_rise);
      else if (sync_rise && edge_cnt != EDG_MAX)
        edge_cnt <= edge_cnt + 1'b1;
      if (sync_rise)
        idle_cnt <= '0;
      else if (tick && idle_cnt != IDL_MAX)
        idle_cnt <= idle_cnt + 1'b1;
      present <= present_nxt;
      // a flag change wins over a clear in the same cycle
      chg_irq <= (present_nxt != present) | (chg_irq & ~irq_clr);
    end
  end

  // R2
  set_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(present) |-> $past(sync_rise));
  // R3
  clear_on_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(present) |-> ($past(tick) && !$past(sync_rise)));
  // R4
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(tick) && !$past(sync_rise)) |-> $stable(present));
  // R8
  irq_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (present != $past(present)) |-> chg_irq);
  // R9
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(chg_irq) && !$past(irq_clr)) |-> chg_irq);
endmodule

// File: rtl/sync_presence_detector.sv
module sync_presence_detector #(
  parameter int unsigned DIV_SLOW    = 8,
  parameter int unsigned DIV_FAST    = 12,
  parameter int unsigned H_WINDOW    = 1000,
  parameter int unsigned H_SET_EDGES = 10,
  parameter int unsigned H_TIMEOUT   = 100000,
  parameter int unsigned V_WINDOW    = 100000,
  parameter int unsigned V_SET_EDGES = 4,
  parameter int unsigned V_TIMEOUT   = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hsync_in,
  input  logic vsync_in,
  input  logic base_sel,
  input  logic h_irq_clr,
  input  logic v_irq_clr,
  output logic h_present,
  output logic v_present,
  output logic h_chg_irq,
  output logic v_chg_irq
);
  import sync_presence_pkg::*;

  logic                tick;
  logic [NUM_CH-1:0]   sync_v, clr_v, pres_v, irq_v;

  assign sync_v = {vsync_in, hsync_in};
  assign clr_v  = {v_irq_clr, h_irq_clr};

  sync_tick_prescaler #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_prescaler (
    .clk(clk), .rst_n(rst_n), .base_sel(base_sel), .tick(tick)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam int unsigned WIN = (ch == CH_H) ? H_WINDOW    : V_WINDOW;
    localparam int unsigned SET = (ch == CH_H) ? H_SET_EDGES : V_SET_EDGES;
    localparam int unsigned TMO = (ch == CH_H) ? H_TIMEOUT   : V_TIMEOUT;
    sync_presence_channel #(.WINDOW(WIN), .SET_EDGES(SET), .TIMEOUT(TMO)) u_chan (
      .clk(clk), .rst_n(rst_n), .tick(tick), .sync_in(sync_v[ch]),
      .irq_clr(clr_v[ch]), .present(pres_v[ch]), .chg_irq(irq_v[ch])
    );
  end

  assign h_present = pres_v[CH_H];
  assign v_present = pres_v[CH_V];
  assign h_chg_irq = irq_v[CH_H];
  assign v_chg_irq = irq_v[CH_V];
endmodule

// File: tb/test_sync_presence_detector.sv
module test_sync_presence_detector;
  localparam int DS = 2, DF = 3;
  localparam int HW = 8,  HS = 4, HT = 20;
  localparam int VW = 16, VS = 2, VT = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hs = 1'b0, vs = 1'b0, sel = 1'b0, hclr = 1'b0, vclr = 1'b0;
  logic hp, vp, hi, vi;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  sync_presence_detector #(
    .DIV_SLOW(DS), .DIV_FAST(DF), .H_WINDOW(HW), .H_SET_EDGES(HS), .H_TIMEOUT(HT),
    .V_WINDOW(VW), .V_SET_EDGES(VS), .V_TIMEOUT(VT)
  ) i_sync_presence_detector (
    .clk(clk), .rst_n(rst_n), .hsync_in(hs), .vsync_in(vs), .base_sel(sel),
    .h_irq_clr(hclr), .v_irq_clr(vclr), .h_present(hp), .v_present(vp),
    .h_chg_irq(hi), .v_chg_irq(vi)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; hs = 1'b0; vs = 1'b0; hclr = 1'b0; vclr = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // n pulses, one cycle wide, period_cyc cycles apart
  task automatic pulses(input int period_cyc, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); hs = 1'b1; vs = 1'b1;
      @(negedge clk); hs = 1'b0; vs = 1'b0;
      repeat (period_cyc - 2) @(negedge clk);
    end
  endtask

  // expected flag after a train: 1 set, 0 not set, -1 undecided by alignment
  function automatic int exp_set(input int w, input int s, input int p);
    if (w / p >= s) return 1;
    if ((w + p - 1) / p < s) return 0;
    return -1;
  endfunction

  task automatic collide(input int clr_at, output int kset);
    do_reset();
    sel = 1'b0;
    kset = -1;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (hp && kset < 0) kset = k;
      hclr = (k == clr_at);
      hs = (k % 2 == 0);
    end
    hclr = 1'b0; hs = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int eh, ev, ks, kdummy;
    do_reset();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "h_present", hp, 0); chk("R1", "v_present", vp, 0);
    chk("R1", "h_chg_irq", hi, 0); chk("R1", "v_chg_irq", vi, 0);

    // sweep: both time bases, pulse periods 1..30 ticks (R2 R5 R7 R8)
    for (int s = 0; s < 2; s++) begin
      for (int p = 1; p <= 30; p++) begin
        int div;
        div = (s == 0) ? DS : DF;
        do_reset();
        sel = s[0];
        pulses(p * div, 64 / p + 1);
        repeat (4) @(negedge clk);
        eh = exp_set(HW, HS, p);
        ev = exp_set(VW, VS, p);
        chk("R2", $sformatf("h flag sel=%0d p=%0d", s, p), hp, eh);
        chk("R8", $sformatf("h irq sel=%0d p=%0d", s, p), hi, eh);
        if (ev >= 0) begin
          chk("R5", $sformatf("v flag sel=%0d p=%0d", s, p), vp, ev);
          chk("R8", $sformatf("v irq sel=%0d p=%0d", s, p), vi, ev);
        end
      end
    end

    // R7: 6-cycle period is 3 ticks at slow base, 2 ticks at fast base
    do_reset(); sel = 1'b0; pulses(6, 12); repeat (4) @(negedge clk);
    chk("R7", "slow base 6-cycle h flag", hp, 0);
    do_reset(); sel = 1'b1; pulses(6, 12); repeat (4) @(negedge clk);
    chk("R7", "fast base 6-cycle h flag", hp, 1);

    // R4 hold at 0 between limits
    do_reset(); sel = 1'b0; pulses(10 * DS, 10); repeat (4) @(negedge clk);
    chk("R4", "h stays 0 at 10 ticks", hp, 0);
    chk("R4", "h irq stays 0", hi, 0);

    // R4 hold at 1, then R9 clear, then R3/R6 timeout with R8 on fall
    do_reset(); sel = 1'b0; pulses(DS, 40); repeat (4) @(negedge clk);
    chk("R2", "h set by fast train", hp, 1);
    chk("R5", "v set by fast train", vp, 1);
    hclr = 1'b1; vclr = 1'b1; @(negedge clk); hclr = 1'b0; vclr = 1'b0;
    @(negedge clk);
    chk("R9", "h irq cleared", hi, 0); chk("R9", "v irq cleared", vi, 0);
    pulses(10 * DS, 10);
    chk("R4", "h stays 1 at 10 ticks", hp, 1);
    chk("R4", "v stays 1 at 10 ticks", vp, 1);
    chk("R4", "h irq unchanged", hi, 0);
    // last pulse started 10*DS cycles ago at most; restart timing after it
    pulses(DS, 1);
    repeat ((HT - 2) * DS - DS) @(negedge clk);
    chk("R3", "h still 1 before timeout", hp, 1);
    repeat ((HT + 1) * DS + 6 - (HT - 2) * DS) @(negedge clk);
    chk("R3", "h cleared after timeout", hp, 0);
    chk("R8", "h irq on fall", hi, 1);
    chk("R6", "v still 1 before its timeout", vp, 1);
    repeat ((VT + 1) * DS + 6 - ((HT + 1) * DS + 6)) @(negedge clk);
    chk("R6", "v cleared after timeout", vp, 0);
    chk("R8", "v irq on fall", vi, 1);

    // R9 collision: clear on the exact edge the flag sets
    collide(-1, ks);
    chk("R2", "collision reference set seen", (ks > 0) ? 1 : 0, 1);
    collide(ks - 1, kdummy);
    chk("R9", "clear with same-cycle change keeps irq", hi, 1);
    collide(ks, kdummy);
    chk("R9", "clear one cycle after change drops irq", hi, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule